// File: doc/BRIEF.md
# Pattern-Triggered Capture Recorder

This block is one receive channel of a small logic analyser. Every clock it sees a 28-bit word. When the host arms it, it latches a 16-bit trigger value and a don't-care mask. It then spends 256 cycles wiping its capture buffer, and after that it compares the low half of each incoming word against the trigger. The first word that matches starts a capture. The channel then writes the next 256 words into its buffer and stops by itself.

Each stored word keeps the low 24 bits of the received word. The top nibble is replaced by a rolling 4-bit count, so the host can see from the readout that no word was lost. The host polls the state output and reads the buffer through a separate read port. Reads return data only while the channel is idle or finished. A system can place as many channels side by side as it needs, and each one triggers and records independently.

Top module: `trig_capture_rec`

## Requirements
- R1: After reset, `state_o` is 0 (idle), `done` is 0 and `rd_data` is 0.
- R2: When `arm` is sampled high on a clock edge, `state_o` becomes 1 (armed) after that edge. The values on `trig_pattern` and `trig_mask` are latched at the same edge, and this happens from any state.
- R3: For the 256 clock edges that follow an arming edge, the buffer is filled with zeros and no trigger is taken. `state_o` stays 1 even if matching words arrive during that time.
- R4: Once the clear has finished, an armed channel moves to `state_o` = 2 (capturing) at the first edge where `rx_word[15:0]` equals the latched pattern on every bit whose mask bit is 0. Bits 27:16 of the word play no part in the trigger.
- R5: A mask bit of 1 makes the matching trigger bit a don't care. A word that differs from the pattern only in masked bits still triggers, and a word that differs in an unmasked bit does not.
- R6: The word that causes the trigger is not stored. The 256 words that arrive on the following edges are written to addresses 0 to 255 in the order they arrive.
- R7: The stored word at address a is {a mod 16 as a 4-bit count, rx_word[23:0]}, so the top nibble counts up by one from word to word, starting at 0.
- R8: After the 256th stored word, `state_o` becomes 3 (done) and `done` becomes 1. Both hold, and the buffer stays unchanged, until the next arm, whatever words arrive.
- R9: `rd_data` is registered. When `rd_en` is sampled high while `state_o` is 0 or 3, `rd_data` shows the buffer entry at `rd_addr` after that edge. When `rd_en` is sampled high while `state_o` is 1 or 2, `rd_data` shows 0.
- R10: Changes on `trig_pattern` and `trig_mask` after the arming edge have no effect on the trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start a clear, latch the trigger settings and arm |
| trig_pattern | input | 16 | Trigger value for the low word half |
| trig_mask | input | 16 | 1 = don't care for that trigger bit |
| rx_word | input | 28 | Incoming word, one per clock |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 8 | Host read address |
| rd_data | output | 28 | Read data, one cycle after the strobe |
| state_o | output | 2 | 0 idle, 1 armed, 2 capturing, 3 done |
| done | output | 1 | High when the capture has finished |

## Verification
The hardest case to reach is a matching word that arrives during the clear. The only sign of the clear at the ports is that the channel stays armed, so the stimulus sends a word that satisfies the trigger on every one of the 256 clear cycles. It then checks that the state is still armed right after the clear ends. On the next edges it sends words that differ from the trigger in one unmasked bit, or that equal a pattern value driven after the arm. The trigger is fired by a word whose upper bits differ from those of the blocked words. Each capture is then read back in full and compared with values the bench computes from the word index.

// File: rtl/trig_capture_rec.sv
module trig_capture_rec #(
  parameter int DATA_W = 28,
  parameter int TRIG_W = 16,
  parameter int DEPTH  = 256,
  parameter int NIB_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     arm,
  input  logic [TRIG_W-1:0]        trig_pattern,
  input  logic [TRIG_W-1:0]        trig_mask,
  input  logic [DATA_W-1:0]        rx_word,
  input  logic                     rd_en,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [DATA_W-1:0]        rd_data,
  output logic [1:0]               state_o,
  output logic                     done
);
  localparam int AW = $clog2(DEPTH);
  localparam int KEEP_W = DATA_W - NIB_W;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_ARMED = 2'd1, S_CAPT = 2'd2, S_DONE = 2'd3} st_t;

  st_t               state;
  logic [AW-1:0]     ptr;
  logic              clr_busy;
  logic [TRIG_W-1:0] pat_q, mask_q;
  logic [DATA_W-1:0] mem [DEPTH];

  wire hit    = (((rx_word[TRIG_W-1:0] ^ pat_q) & ~mask_q) == '0);
  wire we     = !arm && ((state == S_ARMED && clr_busy) || state == S_CAPT);
  wire [DATA_W-1:0] wdata = clr_busy ? '0 : {ptr[NIB_W-1:0], rx_word[KEEP_W-1:0]};
  wire rd_ok  = (state == S_IDLE) || (state == S_DONE);

  assign state_o = state;
  assign done    = (state == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      ptr      <= '0;
      clr_busy <= 1'b0;
      pat_q    <= '0;
      mask_q   <= '0;
    end else if (arm) begin
      state    <= S_ARMED;
      ptr      <= '0;
      clr_busy <= 1'b1;
      pat_q    <= trig_pattern;
      mask_q   <= trig_mask;
    end else begin
      case (state)
        S_ARMED: begin
          if (clr_busy) begin
            ptr <= AW'(ptr + 1'b1);
            if (ptr == LAST) clr_busy <= 1'b0;
          end else if (hit) begin
            state <= S_CAPT;
            ptr   <= '0;
          end
        end
        S_CAPT: begin
          ptr <= AW'(ptr + 1'b1);
          if (ptr == LAST) state <= S_DONE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_ok ? mem[rd_addr] : '0;
  end

  assert_arm_enters_armed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> state_o == 2'd1);

  assert_no_trigger_in_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ARMED && clr_busy) |=> state == S_ARMED);

  assert_capture_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CAPT && ptr == LAST && !arm) |=> done);

  assert_done_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> done);

  assert_read_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (state == S_ARMED || state == S_CAPT)) |=> rd_data == '0);

  assert_idle_waits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !arm) |=> state == S_IDLE);
endmodule

// File: tb/tb_trig_capture_rec.sv
`timescale 1ns/1ps
module tb_trig_capture_rec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm = 1'b0;
  logic [15:0] trig_pattern = '0;
  logic [15:0] trig_mask = '0;
  logic [27:0] rx_word = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [27:0] rd_data;
  logic [1:0]  state_o;
  logic        done;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  trig_capture_rec dut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .trig_pattern(trig_pattern),
    .trig_mask(trig_mask), .rx_word(rx_word), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .state_o(state_o), .done(done)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [27:0] act, input logic [27:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [27:0] word_a(input int k);
    return 28'(k * 28'h0123457 + 28'h3A00001);
  endfunction

  function automatic logic [27:0] word_b(input int k);
    return 28'(k * 28'h0F1E2D3 + 28'h5555555);
  endfunction

  task automatic do_arm(input logic [15:0] p, input logic [15:0] m);
    trig_pattern = p;
    trig_mask = m;
    arm = 1'b1;
    tick();
    arm = 1'b0;
  endtask

  task automatic readout(input int which, input string req);
    for (int a = 0; a < 256; a++) begin
      logic [27:0] w;
      w = (which == 0) ? word_a(a) : word_b(a);
      rd_en = 1'b1;
      rd_addr = 8'(a);
      tick();
      chk(req, rd_data, {4'(a), w[23:0]});
    end
    rd_en = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick();
    tick();
    chk("R1 state", 28'(state_o), 28'd0);
    chk("R1 done", 28'(done), 28'd0);
    chk("R1 rd_data", rd_data, 28'd0);
    rst_n = 1'b1;
    tick();
    chk("R1 idle holds", 28'(state_o), 28'd0);

    // Run A: exact pattern, clear shadow, pattern changed after arm
    rx_word = {12'hABC, 16'h1234};
    do_arm(16'h1234, 16'h0000);
    chk("R2 armed", 28'(state_o), 28'd1);
    trig_pattern = 16'hFFFF;
    trig_mask = 16'hFFFF;
    rd_en = 1'b1;
    rd_addr = 8'd0;
    for (int i = 0; i < 256; i++) tick();
    chk("R3 no trigger during clear", 28'(state_o), 28'd1);
    chk("R9 read blocked while armed", rd_data, 28'd0);
    rd_en = 1'b0;
    rx_word = {12'h123, 16'h1235};
    tick();
    chk("R4 unmasked bit differs", 28'(state_o), 28'd1);
    rx_word = {12'h456, 16'hFFFF};
    tick();
    chk("R10 new pattern ignored", 28'(state_o), 28'd1);
    rx_word = {12'h000, 16'h1234};
    tick();
    chk("R4 trigger with other upper bits", 28'(state_o), 28'd2);
    for (int k = 0; k < 256; k++) begin
      rx_word = word_a(k);
      rd_en = (k == 5);
      rd_addr = 8'd0;
      tick();
      if (k == 5) chk("R9 read blocked while capturing", rd_data, 28'd0);
      if (k == 254) chk("R6 still capturing before last", 28'(state_o), 28'd2);
    end
    rd_en = 1'b0;
    chk("R8 done state", 28'(state_o), 28'd3);
    chk("R8 done flag", 28'(done), 28'd1);
    rx_word = {12'hFFF, 16'h1234};
    for (int i = 0; i < 20; i++) tick();
    chk("R8 holds after more matches", 28'(state_o), 28'd3);
    readout(0, "R6 R7 R8 capture A");

    // Run B: masked trigger
    rx_word = 28'h0000000;
    do_arm(16'h00F0, 16'h0F0F);
    chk("R2 rearm from done", 28'(state_o), 28'd1);
    for (int i = 0; i < 256; i++) tick();
    tick();
    chk("R4 nonmatching idle words", 28'(state_o), 28'd1);
    rx_word = {12'h777, 16'h10F0};
    tick();
    chk("R5 unmasked bit 12 blocks", 28'(state_o), 28'd1);
    rx_word = {12'h888, 16'h0AF5};
    tick();
    chk("R5 masked bits ignored", 28'(state_o), 28'd2);
    for (int k = 0; k < 256; k++) begin
      rx_word = word_b(k);
      tick();
    end
    chk("R8 done after run B", 28'(done), 28'd1);
    readout(1, "R5 R6 R7 capture B");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule